// File: doc/BRIEF.md
# Triggered Binary Hit Pipeline Readout

This block sits behind 128 discriminator channels. On every bunch-crossing clock it records one hit bit from each channel in a 256-entry circular pipeline, so each sample stays available for the whole first-level trigger latency. When a trigger pulse arrives, the block takes the sample written a programmed number of clocks earlier and copies it, together with the pipeline address it came from, into a 32-event buffer.

A serializer drains that buffer one event at a time. Each event goes out on a single data line as a 140-bit unsparsified frame, one bit per clock. The frame carries a two-bit start marker, a latency-error flag, a buffer-overflow flag, the 8-bit pipeline address that was read, and then every channel bit. Frames for successive triggers follow each other on the line with no gap between them. The line sits at 0 whenever no frame is being sent.

Top module: `trig_hit_readout`

## Requirements
- R1: On every clock edge without reset, the hit vector is written to the pipeline. A trigger sampled at an edge with latency L (1 to 255) captures the hit vector that was sampled L edges earlier.
- R2: A frame is 140 bits sent MSB-first, one bit per clock. Frame bits 139 and 138 are both 1, bit 137 is the latency-error flag, bit 136 is the overflow flag, bits 135:128 hold the pipeline address, and bits 127:0 hold the channels with channel 0 at bit 127 (sent first) and channel 127 at bit 0.
- R3: Counting the edges since reset was released as n = 0, 1, 2, ..., the address field of a frame captured at edge n equals (n - L) mod 256.
- R4: When the line is idle and the buffer is empty, a trigger at edge T puts the first start bit on the line after edge T+1.
- R5: When the buffer still holds events as a frame's last bit is sent, the next frame's first start bit follows on the very next clock. The line is 0 whenever no frame is in progress.
- R6: The buffer holds at most 32 events. A trigger sampled while it holds 32 events is dropped, even if a frame is loaded at the same edge.
- R7: A dropped trigger sets the overflow flag in the next frame loaded at a later edge. Frames loaded after that one carry the flag as 0 unless another drop occurs.
- R8: If the latency input changes between two edges while the buffer is non-empty or a frame is in progress, the next frame loaded at a later edge carries the latency-error flag as 1.
- R9: A trigger sampled while latency is 0 captures nothing and sets the latency-error flag for the next frame loaded at a later edge.
- R10: A synchronous reset empties the buffer, aborts any frame in progress, clears both pending flags, forces the line to 0 and restarts the pipeline address count at 0. It does not overwrite the stored pipeline samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hits | input | 128 | One binary hit bit per channel, sampled every clock |
| trig | input | 1 | First-level trigger pulse, one event per high clock |
| latency | input | 8 | Distance between write position and read position, in clocks |
| serOut | output | 1 | Serial frame output, 0 when idle |

## Verification
The bench runs one trigger at each of sixteen latencies spread from 1 to 255 over a hit pattern that changes every clock. A wrong read offset, a wrong address or reversed channel order each show up as a mismatch in a different field of the frame. Three consecutive triggers show whether frames join with no gap. A 40-trigger burst fills the buffer, so the count of accepted events and the single overflow frame reveal an off-by-one in the full test. A latency change during readout, a trigger with latency 0, and a reset in the middle of a frame each decide one flag value in the next header, or whether the line goes quiet.

// File: rtl/trig_hit_readout_pkg.sv
package trig_hit_readout_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic push;    // capture the delayed sample into the event buffer
    logic pop;     // load the oldest buffered event into the serializer
    logic shift;   // advance the serializer by one bit
    logic setOvf;  // an event was dropped because the buffer was full
    logic setLat;  // pointer separation broken or invalid latency
  } ctrlStrb_t;

  localparam int START_W = 2;
  localparam int FLAG_W  = 2;

endpackage

// File: rtl/trig_hit_readout_dp.sv
module trig_hit_readout_dp
  import trig_hit_readout_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32,
  localparam int PTR_W     = $clog2(PIPE_DEPTH),
  localparam int BUF_AW    = $clog2(BUF_DEPTH),
  localparam int ENTRY_W   = PTR_W + NCH,
  localparam int FRAME_LEN = START_W + FLAG_W + ENTRY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   hits,
  input  logic [PTR_W-1:0] latency,
  input  ctrlStrb_t        strb,
  input  logic             frameActive,
  output logic             serOut,
  output logic [PTR_W-1:0] wrPtr
);

  logic [NCH-1:0]     pipeMem [PIPE_DEPTH];
  logic [ENTRY_W-1:0] bufMem  [BUF_DEPTH];
  logic [PTR_W-1:0]   rdAddr;
  logic [NCH-1:0]     rdData;
  logic [NCH-1:0]     rdRev;
  logic [BUF_AW-1:0]  bufWrIdx, bufRdIdx;
  logic               ovfPend, latPend;
  logic [FRAME_LEN-1:0] shReg;

  // Latency pipeline: one sample written per clock, read at a fixed offset.
  assign rdAddr = wrPtr - latency;
  assign rdData = pipeMem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rst) pipeMem[wrPtr] <= hits;
  end

  always_ff @(posedge clk) begin
    if (rst) wrPtr <= '0;
    else     wrPtr <= wrPtr + 1'b1;
  end

  // Channel 0 leads the channel field on the line.
  for (genvar i = 0; i < NCH; i++) begin : g_rev
    assign rdRev[NCH-1-i] = rdData[i];
  end

  // Event buffer, storage only; occupancy lives in the control unit.
  always_ff @(posedge clk) begin
    if (strb.push) bufMem[bufWrIdx] <= {rdAddr, rdRev};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufWrIdx <= '0;
      bufRdIdx <= '0;
    end else begin
      if (strb.push) bufWrIdx <= bufWrIdx + 1'b1;
      if (strb.pop)  bufRdIdx <= bufRdIdx + 1'b1;
    end
  end

  // Pending header flags: sampled into a frame at load, set events of the
  // load cycle itself are kept for the following frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfPend <= 1'b0;
      latPend <= 1'b0;
    end else begin
      ovfPend <= (strb.pop ? 1'b0 : ovfPend) | strb.setOvf;
      latPend <= (strb.pop ? 1'b0 : latPend) | strb.setLat;
    end
  end

  // Serializer.
  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
    end else if (strb.pop) begin
      shReg <= {{START_W{1'b1}}, latPend, ovfPend, bufMem[bufRdIdx]};
    end else if (strb.shift) begin
      shReg <= {shReg[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign serOut = frameActive & shReg[FRAME_LEN-1];

endmodule

// File: rtl/trig_hit_readout_ctrl.sv
module trig_hit_readout_ctrl
  import trig_hit_readout_pkg::*;
#(
  parameter int BUF_DEPTH  = 32,
  parameter int FRAME_LEN  = 140,
  parameter int PTR_W      = 8,
  localparam int BUF_AW    = $clog2(BUF_DEPTH),
  localparam int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [PTR_W-1:0] latency,
  output ctrlStrb_t        strb,
  output logic [BUF_AW:0]  fifoCount,
  output logic             frameActive
);

  localparam logic [BUF_AW:0]  FULL_CNT = (BUF_AW+1)'(BUF_DEPTH);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [PTR_W-1:0] latQ;
  logic busy, full, lastBit, latZero;

  always_comb begin
    busy        = (fifoCount != '0) || frameActive;
    full        = (fifoCount == FULL_CNT);
    latZero     = (latency == '0);
    lastBit     = frameActive && (bitCnt == LAST_BIT);
    strb.pop    = (!frameActive || lastBit) && (fifoCount != '0);
    strb.push   = trig && !latZero && !full;
    strb.setOvf = trig && !latZero && full;
    strb.setLat = (trig && latZero) || (busy && (latency != latQ));
    strb.shift  = frameActive && !lastBit;
  end

  // Latency as seen at the previous edge, tracked through reset too.
  always_ff @(posedge clk) latQ <= latency;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifoCount   <= '0;
      frameActive <= 1'b0;
      bitCnt      <= '0;
    end else begin
      unique case ({strb.push, strb.pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
      if (strb.pop)    frameActive <= 1'b1;
      else if (lastBit) frameActive <= 1'b0;
      if (strb.pop)        bitCnt <= '0;
      else if (strb.shift) bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/trig_hit_readout.sv
module trig_hit_readout
  import trig_hit_readout_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32,
  localparam int PTR_W     = $clog2(PIPE_DEPTH),
  localparam int BUF_AW    = $clog2(BUF_DEPTH),
  localparam int FRAME_LEN = START_W + FLAG_W + PTR_W + NCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   hits,
  input  logic             trig,
  input  logic [PTR_W-1:0] latency,
  output logic             serOut
);

  ctrlStrb_t        strb;
  logic [BUF_AW:0]  fifoCount;
  logic             frameActive;
  logic [PTR_W-1:0] wrPtr;
  logic             popStrb;

  assign popStrb = strb.pop;

  trig_hit_readout_ctrl #(
    .BUF_DEPTH (BUF_DEPTH),
    .FRAME_LEN (FRAME_LEN),
    .PTR_W     (PTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .latency     (latency),
    .strb        (strb),
    .fifoCount   (fifoCount),
    .frameActive (frameActive)
  );

  trig_hit_readout_dp #(
    .NCH        (NCH),
    .PIPE_DEPTH (PIPE_DEPTH),
    .BUF_DEPTH  (BUF_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .hits        (hits),
    .latency     (latency),
    .strb        (strb),
    .frameActive (frameActive),
    .serOut      (serOut),
    .wrPtr       (wrPtr)
  );

endmodule

// File: rtl/trig_hit_readout_chk.sv
module trig_hit_readout_chk #(
  parameter int BUF_DEPTH = 32,
  parameter int PTR_W     = 8,
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic [PTR_W-1:0] latency,
  input logic             serOut,
  input logic [BUF_AW:0]  fifoCount,
  input logic             frameActive,
  input logic             popStrb,
  input logic [PTR_W-1:0] wrPtr
);

  localparam logic [BUF_AW:0] FULL_CNT = (BUF_AW+1)'(BUF_DEPTH);

  logic rstQ = 1'b0;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      AST_RESET_IDLE: assert (!serOut && !frameActive && fifoCount == '0) // R10
        else $error("line or buffer not cleared by reset");
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= FULL_CNT); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (trig && fifoCount == FULL_CNT && !popStrb) |=> (fifoCount == FULL_CNT)); // R6

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (trig && latency != '0 && fifoCount < FULL_CNT && !popStrb)
      |=> (fifoCount == $past(fifoCount) + 1'b1)); // R1

  AST_ZERO_LAT_DROP: assert property (@(posedge clk) disable iff (rst)
    (trig && latency == '0 && !popStrb) |=> $stable(fifoCount)); // R9

  AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(frameActive) |-> serOut); // R2

  AST_WRPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wrPtr == $past(wrPtr) + 1'b1)); // R3

endmodule

bind trig_hit_readout trig_hit_readout_chk #(
  .BUF_DEPTH (BUF_DEPTH),
  .PTR_W     (PTR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig        (trig),
  .latency     (latency),
  .serOut      (serOut),
  .fifoCount   (fifoCount),
  .frameActive (frameActive),
  .popStrb     (popStrb),
  .wrPtr       (wrPtr)
);

// File: tb/trig_hit_readout_bench.sv
module trig_hit_readout_bench;

  localparam int NCH   = 128;
  localparam int DEPTH = 256;
  localparam int BUFN  = 32;
  localparam int FLEN  = 140;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           trig = 1'b0;
  logic [7:0]     latency = 8'd1;
  logic [NCH-1:0] hits = '0;
  logic           serOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trig_hit_readout u_trig_hit_readout (
    .clk     (clk),
    .rst     (rst),
    .hits    (hits),
    .trig    (trig),
    .latency (latency),
    .serOut  (serOut)
  );

  // Reference model state, built from the requirements.
  logic [NCH-1:0]  hist [DEPTH];
  logic [135:0]    fifoQ [$];
  logic [FLEN-1:0] curFrame;
  logic [FLEN-1:0] gotFrame;
  int              occ = 0;
  int              rem = 0;
  int              n = 0;
  int              cyc = 0;
  int              frameIdx = 0;
  logic            ovfP = 1'b0;
  logic            latP = 1'b0;
  logic [7:0]      prevLat = 8'd1;

  function automatic logic [NCH-1:0] hitPat(int c);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++)
      v[i] = (((i * 5 + c * 3) % 11) == 0) || (i == (c % NCH));
    return v;
  endfunction

  task automatic modelEdge(input logic t);
    logic setL, setO, doPush, doLoad, busy;
    logic [135:0] pl;
    int a;
    if (rst) begin
      occ = 0; rem = 0; ovfP = 1'b0; latP = 1'b0;
      fifoQ.delete(); n = 0; prevLat = latency;
      return;
    end
    busy   = (occ > 0) || (rem > 0);
    setL   = (t && latency == 8'd0) || (latency != prevLat && busy);
    setO   = t && latency != 8'd0 && occ == BUFN;
    doPush = t && latency != 8'd0 && occ < BUFN;
    doLoad = (rem <= 1) && (occ > 0);
    hist[n] = hits;
    if (doLoad) begin
      pl = fifoQ.pop_front();
      curFrame = {2'b11, latP, ovfP, pl};
      rem = FLEN; occ--;
      latP = setL; ovfP = setO;
    end else begin
      if (rem > 0) rem--;
      latP = latP | setL; ovfP = ovfP | setO;
    end
    if (doPush) begin
      a = (n - int'(latency) + DEPTH) % DEPTH;
      pl[135:128] = a[7:0];
      for (int i = 0; i < NCH; i++) pl[127-i] = hist[a][i];
      fifoQ.push_back(pl);
      occ++;
    end
    prevLat = latency;
    n = (n + 1) % DEPTH;
  endtask

  task automatic finishFrame();
    checks += 4;
    if (gotFrame[139:138] !== curFrame[139:138]) begin
      errors++;
      $display("FAIL R2 frame %0d start bits got %b exp %b", frameIdx, gotFrame[139:138], curFrame[139:138]);
    end
    if (gotFrame[137:136] !== curFrame[137:136]) begin
      errors++;
      $display("FAIL R7 R8 R9 R10 frame %0d flags got %b exp %b", frameIdx, gotFrame[137:136], curFrame[137:136]);
    end
    if (gotFrame[135:128] !== curFrame[135:128]) begin
      errors++;
      $display("FAIL R3 frame %0d address got %0h exp %0h", frameIdx, gotFrame[135:128], curFrame[135:128]);
    end
    if (gotFrame[127:0] !== curFrame[127:0]) begin
      errors++;
      $display("FAIL R1 R5 frame %0d channels got %h exp %h", frameIdx, gotFrame[127:0], curFrame[127:0]);
    end
    frameIdx++;
  endtask

  task automatic sampleOut();
    if (rem > 0) begin
      gotFrame[rem-1] = serOut;
      if (rem == 1) finishFrame();
    end else begin
      checks++;
      if (serOut !== 1'b0) begin
        errors++;
        $display("FAIL R5 R6 R9 R10 idle line got %b exp 0 at cycle %0d", serOut, cyc);
      end
    end
  endtask

  // Apply the current drive values across one rising edge, then sample.
  task automatic tick(input logic t);
    trig = t;
    hits = hitPat(cyc);
    modelEdge(t);
    cyc++;
    @(negedge clk);
    sampleOut();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick(1'b0);
  endtask

  task automatic singleShot(input logic [7:0] lat);
    latency = lat;
    tick(1'b1);
    checks++;
    if (serOut !== 1'b0) begin
      errors++;
      $display("FAIL R4 line after trigger edge got %b exp 0", serOut);
    end
    tick(1'b0);
    checks++;
    if (serOut !== 1'b1) begin
      errors++;
      $display("FAIL R4 start bit one edge later got %b exp 1", serOut);
    end
    idle(FLEN + 2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog got running exp finished");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state
    rst = 1'b1;
    idle(4);
    checks++;
    if (serOut !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset output got %b exp 0", serOut);
    end
    rst = 1'b0;
    latency = 8'd1;
    idle(300);

    // R1 R3 R4: one trigger per latency, spread over the full range
    for (int k = 0; k < 16; k++) singleShot((k == 15) ? 8'd255 : 8'(1 + k * 17));

    // R5: three consecutive triggers, frames back to back
    latency = 8'd5;
    tick(1'b1); tick(1'b1); tick(1'b1);
    idle(3 * FLEN + 5);

    // R8: latency changed while frames are pending
    latency = 8'd10;
    tick(1'b1); tick(1'b1);
    idle(20);
    latency = 8'd30;
    tick(1'b1);
    idle(3 * FLEN + 5);

    // R6 R7: burst of 40 triggers against a 32-event buffer
    latency = 8'd3;
    for (int k = 0; k < 40; k++) tick(1'b1);
    idle(33 * FLEN + 10);

    // R9: trigger with latency 0 is dropped and flagged
    latency = 8'd0;
    tick(1'b1);
    idle(5);
    latency = 8'd7;
    idle(2);
    tick(1'b1);
    idle(FLEN + 5);

    // R10: reset in mid-frame discards the frame and the pending flag
    latency = 8'd0;
    tick(1'b1);
    latency = 8'd9;
    idle(2);
    tick(1'b1);
    idle(50);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(20);
    tick(1'b1);
    idle(FLEN + 5);

    checks++;
    if (frameIdx != 16 + 3 + 3 + 33 + 1 + 1) begin
      errors++;
      $display("FAIL R6 frame count got %0d exp %0d", frameIdx, 16 + 3 + 3 + 33 + 1 + 1);
    end

    summary();
    $finish;
  end

endmodule